// File: doc/BRIEF.md
# Pipelined Address Output Stage

This stage sits between a processor core and its external memory bus. Each bus cycle is split into a first and a second phase. A phase flag, sampled on a fast system clock, tells the stage which phase is in progress. The core presents the address and access attributes of the next transfer during the second phase of the cycle before that transfer. The attributes are transfer size, write strobe, lock, opcode-fetch and translate. The stage launches these values onto the bus in one of two ways, chosen by a mode input:

- **Early:** the values go out in that same second phase.
- **Late:** the values go out one phase later, in the first phase of the transfer cycle itself.

A level-controlled freeze input works like a static latch. While it is closed, the bus address and all attribute outputs keep their values for as long as needed, which suits slow ROM devices that need the address held past the end of the cycle.

The stage does not drive pads. It gives registered output-enable flags instead. The address flag covers the address bus and the attribute outputs. The data flag covers the data bus. An address-enable input releases the address flag. A data-enable input releases the data flag. A test-enable input releases both flags at once. Every output is registered on the fast clock.

Top module: `bus_addr_stage`

## Requirements
- R1: While `rst` is high, the bus address, all bus attributes and both enable flags are 0 after the next clock edge.
- R2: With `pipe_en`=1 and `latch_open`=1, each clock edge at which `ph2`=1 loads the core address and attributes onto the bus outputs, visible after that edge. Edges at which `ph2`=0 leave the bus outputs unchanged.
- R3: With `pipe_en`=0 and `latch_open`=1, edges at which `ph2`=1 leave the bus outputs unchanged. Each edge at which `ph2`=0 loads the core address and attributes that were sampled at the most recent edge with `ph2`=1.
- R4: While `latch_open`=0, the bus address and all bus attributes hold their value for any number of cycles. This holds whatever the phase, the mode or the core inputs are. After `latch_open` returns to 1, loading resumes under R2 or R3.
- R5: One edge after the inputs are applied, `addr_oe` equals `addr_en & test_en` and `data_oe` equals `data_en & test_en`.
- R6: When `test_en`=0, both `addr_oe` and `data_oe` are 0 after the next edge, whatever `addr_en` and `data_en` are.
- R7: The enable flags follow R5 even while the freeze latch is closed.
- R8: The 2-bit size field is carried unchanged. The codes are 2'b00 byte, 2'b01 halfword, 2'b10 word, and 2'b11 reserved, which is also carried unaltered.
- R9: While the core holds `core_lock`=1 through a locked sequence, `bus_lock` stays 1 on every cycle from its first launch. It returns to 0 at the first launch after the core drops `core_lock`.
- R10: `bus_write`, `bus_fetch` and `bus_trans` launch at the same edge as the address, with no skew between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| ph2 | input | 1 | Phase flag: 1 = second phase, 0 = first phase |
| pipe_en | input | 1 | 1 = early launch, 0 = late launch |
| latch_open | input | 1 | 1 = transparent, 0 = freeze bus address and attributes |
| core_addr | input | ADDR_W | Next-transfer address from the core |
| core_size | input | 2 | Next-transfer size code |
| core_write | input | 1 | Next transfer is a write |
| core_lock | input | 1 | Next transfer is part of a locked sequence |
| core_fetch | input | 1 | Next transfer is an opcode fetch |
| core_trans | input | 1 | Translate attribute of next transfer |
| addr_en | input | 1 | 0 releases address bus and attributes |
| data_en | input | 1 | 0 releases the data bus |
| test_en | input | 1 | 0 releases address, attributes and data |
| bus_addr | output | ADDR_W | Launched address |
| bus_size | output | 2 | Launched size code |
| bus_write | output | 1 | Launched write attribute |
| bus_lock | output | 1 | Launched lock attribute |
| bus_fetch | output | 1 | Launched opcode-fetch attribute |
| bus_trans | output | 1 | Launched translate attribute |
| addr_oe | output | 1 | Drive flag for address bus and attributes |
| data_oe | output | 1 | Drive flag for data bus |

## Verification
The hardest case to reach is late launch. Here the value that reaches the bus is not the core input of the current edge but the one captured at the final second-phase edge before the phase changes. Proving this needs a second-phase window that holds two different addresses in a row, followed by a first-phase window in which the core already shows a third address. The stimulus walks through exactly that sequence. It then checks that only the second address appears, and that it stays through the whole first phase. The freeze case is reached in a similar way: the latch is closed, then the phase, the launch mode, the core address and the address enable are all changed underneath it.

// File: rtl/bus_addr_stage_pkg.sv
package bus_addr_stage_pkg;
  localparam int SIZE_W = 2;

  typedef enum logic [SIZE_W-1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  typedef struct packed {
    acc_size_e size;
    logic      write;
    logic      lock;
    logic      fetch;
    logic      trans;
  } attr_t;

  localparam int ATTR_W = $bits(attr_t);
endpackage

// File: rtl/bas_launch.sv
module bas_launch
  import bus_addr_stage_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ph2,
  input  logic              pipe_en,
  input  logic              latch_open,
  input  logic [ADDR_W-1:0] nxt_addr,
  input  attr_t             nxt_attr,
  output logic              load,
  output logic [ADDR_W-1:0] load_addr,
  output attr_t             load_attr
);
  // Second-phase capture used by the late-launch path.
  logic [ADDR_W-1:0] held_addr;
  attr_t             held_attr;
  logic              in_window;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_addr <= '0;
      held_attr <= '0;
    end else if (ph2) begin
      held_addr <= nxt_addr;
      held_attr <= nxt_attr;
    end
  end

  always_comb begin
    in_window = pipe_en ? ph2 : ~ph2;
    load      = in_window & latch_open;
    load_addr = pipe_en ? nxt_addr : held_addr;
    load_attr = pipe_en ? nxt_attr : held_attr;
  end
endmodule

// File: rtl/bas_out_reg.sv
module bas_out_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/bas_oe_ctrl.sv
module bas_oe_ctrl #(
  parameter int N_GRP = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             test_en,
  input  logic [N_GRP-1:0] grp_en,
  output logic [N_GRP-1:0] grp_oe
);
  for (genvar g = 0; g < N_GRP; g++) begin : g_oe
    always_ff @(posedge clk) begin
      if (rst) grp_oe[g] <= 1'b0;
      else     grp_oe[g] <= grp_en[g] & test_en;
    end
  end
endmodule

// File: rtl/bus_addr_stage.sv
module bus_addr_stage
  import bus_addr_stage_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ph2,
  input  logic              pipe_en,
  input  logic              latch_open,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [1:0]        core_size,
  input  logic              core_write,
  input  logic              core_lock,
  input  logic              core_fetch,
  input  logic              core_trans,
  input  logic              addr_en,
  input  logic              data_en,
  input  logic              test_en,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_size,
  output logic              bus_write,
  output logic              bus_lock,
  output logic              bus_fetch,
  output logic              bus_trans,
  output logic              addr_oe,
  output logic              data_oe
);
  localparam int BUS_W = ADDR_W + ATTR_W;
  localparam int GRP_ADDR = 0;
  localparam int GRP_DATA = 1;
  localparam int N_GRP = 2;

  attr_t             nxt_attr;
  attr_t             load_attr;
  attr_t             out_attr;
  logic [ADDR_W-1:0] load_addr;
  logic [ADDR_W-1:0] out_addr;
  logic              load;
  logic [N_GRP-1:0]  grp_en;
  logic [N_GRP-1:0]  grp_oe;

  always_comb begin
    nxt_attr.size  = acc_size_e'(core_size);
    nxt_attr.write = core_write;
    nxt_attr.lock  = core_lock;
    nxt_attr.fetch = core_fetch;
    nxt_attr.trans = core_trans;
  end

  bas_launch #(.ADDR_W(ADDR_W)) u_launch (
    .clk(clk), .rst(rst), .ph2(ph2), .pipe_en(pipe_en),
    .latch_open(latch_open), .nxt_addr(core_addr), .nxt_attr(nxt_attr),
    .load(load), .load_addr(load_addr), .load_attr(load_attr)
  );

  bas_out_reg #(.W(BUS_W)) u_out (
    .clk(clk), .rst(rst), .en(load),
    .d({load_addr, load_attr}),
    .q({out_addr, out_attr})
  );

  always_comb begin
    grp_en           = '0;
    grp_en[GRP_ADDR] = addr_en;
    grp_en[GRP_DATA] = data_en;
  end

  bas_oe_ctrl #(.N_GRP(N_GRP)) u_oe (
    .clk(clk), .rst(rst), .test_en(test_en),
    .grp_en(grp_en), .grp_oe(grp_oe)
  );

  assign bus_addr  = out_addr;
  assign bus_size  = out_attr.size;
  assign bus_write = out_attr.write;
  assign bus_lock  = out_attr.lock;
  assign bus_fetch = out_attr.fetch;
  assign bus_trans = out_attr.trans;
  assign addr_oe   = grp_oe[GRP_ADDR];
  assign data_oe   = grp_oe[GRP_DATA];
endmodule

// File: rtl/bus_addr_stage_chk.sv
module bus_addr_stage_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              ph2,
  input logic              pipe_en,
  input logic              latch_open,
  input logic [ADDR_W-1:0] core_addr,
  input logic [1:0]        core_size,
  input logic              addr_en,
  input logic              data_en,
  input logic              test_en,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_size,
  input logic              bus_write,
  input logic              bus_lock,
  input logic              bus_fetch,
  input logic              bus_trans,
  input logic              addr_oe,
  input logic              data_oe
);
  logic [ADDR_W+5:0] bus_all;
  assign bus_all = {bus_addr, bus_size, bus_write, bus_lock, bus_fetch, bus_trans};

  // R2
  early_load_chk: assert property (@(posedge clk) disable iff (rst)
    (pipe_en && ph2 && latch_open) |=> (bus_addr == $past(core_addr) && bus_size == $past(core_size)));

  // R2
  early_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (pipe_en && !ph2) |=> $stable(bus_all));

  // R3
  late_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!pipe_en && ph2) |=> $stable(bus_all));

  // R4
  freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !latch_open |=> $stable(bus_all));

  // R5
  oe_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (addr_oe == $past(addr_en && test_en) && data_oe == $past(data_en && test_en)));

  // R6
  test_release_chk: assert property (@(posedge clk) disable iff (rst)
    !test_en |=> (!addr_oe && !data_oe));
endmodule

bind bus_addr_stage bus_addr_stage_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .ph2(ph2), .pipe_en(pipe_en), .latch_open(latch_open),
  .core_addr(core_addr), .core_size(core_size), .addr_en(addr_en),
  .data_en(data_en), .test_en(test_en), .bus_addr(bus_addr), .bus_size(bus_size),
  .bus_write(bus_write), .bus_lock(bus_lock), .bus_fetch(bus_fetch),
  .bus_trans(bus_trans), .addr_oe(addr_oe), .data_oe(data_oe)
);

// File: tb/bus_addr_stage_bench.sv
module bus_addr_stage_bench;
  localparam int ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ph2 = 1'b0;
  logic              pipe_en = 1'b1;
  logic              latch_open = 1'b1;
  logic [ADDR_W-1:0] core_addr = '0;
  logic [1:0]        core_size = 2'b10;
  logic              core_write = 1'b0;
  logic              core_lock = 1'b0;
  logic              core_fetch = 1'b0;
  logic              core_trans = 1'b0;
  logic              addr_en = 1'b1;
  logic              data_en = 1'b1;
  logic              test_en = 1'b1;
  logic [ADDR_W-1:0] bus_addr;
  logic [1:0]        bus_size;
  logic              bus_write, bus_lock, bus_fetch, bus_trans, addr_oe, data_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bus_addr_stage #(.ADDR_W(ADDR_W)) u_bus_addr_stage (
    .clk(clk), .rst(rst), .ph2(ph2), .pipe_en(pipe_en), .latch_open(latch_open),
    .core_addr(core_addr), .core_size(core_size), .core_write(core_write),
    .core_lock(core_lock), .core_fetch(core_fetch), .core_trans(core_trans),
    .addr_en(addr_en), .data_en(data_en), .test_en(test_en),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_write(bus_write),
    .bus_lock(bus_lock), .bus_fetch(bus_fetch), .bus_trans(bus_trans),
    .addr_oe(addr_oe), .data_oe(data_oe)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive one fast-clock step, then sample just after the edge.
  task automatic step(input logic ph, input logic [ADDR_W-1:0] a);
    @(negedge clk);
    ph2 = ph;
    core_addr = a;
    @(posedge clk);
    #2;
  endtask

  task automatic t_reset;
    step(1'b1, 32'hDEAD_0000);
    step(1'b0, 32'hDEAD_0004);
    check("R1 addr", bus_addr, 0);
    check("R1 attrs", {bus_size, bus_write, bus_lock, bus_fetch, bus_trans}, 0);
    check("R1 oe", {addr_oe, data_oe}, 0);
    rst = 1'b0;
  endtask

  task automatic t_early;
    pipe_en = 1'b1;
    step(1'b1, 32'h0000_1000);
    check("R2 load ph2", bus_addr, 32'h0000_1000);
    step(1'b0, 32'h0000_2000);
    check("R2 hold ph1", bus_addr, 32'h0000_1000);
    step(1'b0, 32'h0000_3000);
    check("R2 hold ph1 b", bus_addr, 32'h0000_1000);
    step(1'b1, 32'h0000_4000);
    check("R2 next ph2", bus_addr, 32'h0000_4000);
  endtask

  task automatic t_late;
    pipe_en = 1'b0;
    step(1'b1, 32'h0000_B001);
    check("R3 no load ph2", bus_addr, 32'h0000_4000);
    step(1'b1, 32'h0000_B002);
    check("R3 no load ph2 b", bus_addr, 32'h0000_4000);
    step(1'b0, 32'h0000_B003);
    check("R3 last ph2 value", bus_addr, 32'h0000_B002);
    step(1'b0, 32'h0000_B004);
    check("R3 stays ph1", bus_addr, 32'h0000_B002);
    step(1'b1, 32'h0000_B005);
    check("R3 hold into ph2", bus_addr, 32'h0000_B002);
  endtask

  task automatic t_attrs;
    pipe_en = 1'b1;
    for (int sz = 0; sz < 4; sz++) begin
      core_size  = 2'(sz);
      core_write = sz[0];
      core_fetch = ~sz[0];
      core_trans = sz[1];
      step(1'b1, 32'h0000_C000 + 32'(sz));
      check("R8 size code", bus_size, 64'(sz));
      check("R10 write/fetch/trans", {bus_write, bus_fetch, bus_trans},
            {61'b0, sz[0], ~sz[0], sz[1]});
      check("R10 addr same edge", bus_addr, 32'h0000_C000 + 32'(sz));
    end
  endtask

  task automatic t_lock;
    pipe_en = 1'b0;
    core_lock = 1'b1;
    step(1'b1, 32'h0000_D000);
    step(1'b0, 32'h0000_D004);
    check("R9 lock launched", bus_lock, 1);
    for (int i = 0; i < 4; i++) begin
      step(i[0] ? 1'b0 : 1'b1, 32'h0000_D008 + 32'(i));
      check("R9 lock held", bus_lock, 1);
    end
    core_lock = 1'b0;
    step(1'b1, 32'h0000_D100);
    check("R9 lock held until launch", bus_lock, 1);
    step(1'b0, 32'h0000_D104);
    check("R9 lock dropped", bus_lock, 0);
  endtask

  task automatic t_freeze;
    pipe_en = 1'b1;
    core_size = 2'b01;
    step(1'b1, 32'h0000_E000);
    check("R4 pre-freeze", bus_addr, 32'h0000_E000);
    latch_open = 1'b0;
    core_size = 2'b00;
    core_write = ~core_write;
    step(1'b1, 32'h0000_E100);
    check("R4 frozen ph2", bus_addr, 32'h0000_E000);
    step(1'b0, 32'h0000_E200);
    pipe_en = 1'b0;
    step(1'b0, 32'h0000_E300);
    check("R4 frozen late", bus_addr, 32'h0000_E000);
    check("R4 frozen size", bus_size, 2'b01);
    addr_en = 1'b0;
    step(1'b1, 32'h0000_E400);
    check("R7 oe during freeze", {addr_oe, data_oe}, 2'b01);
    check("R4 frozen addr", bus_addr, 32'h0000_E000);
    addr_en = 1'b1;
    latch_open = 1'b1;
    pipe_en = 1'b1;
    step(1'b1, 32'h0000_E900);
    check("R4 resume", bus_addr, 32'h0000_E900);
    check("R7 oe back", addr_oe, 1);
  endtask

  task automatic t_oe;
    for (int c = 0; c < 8; c++) begin
      addr_en = c[0];
      data_en = c[1];
      test_en = c[2];
      step(1'b1, 32'h0000_F000);
      check("R5 addr_oe", addr_oe, 64'(c[0] & c[2]));
      check("R5 data_oe", data_oe, 64'(c[1] & c[2]));
      if (!c[2]) check("R6 test release", {addr_oe, data_oe}, 0);
    end
    addr_en = 1'b1;
    data_en = 1'b1;
    test_en = 1'b1;
  endtask

  initial begin
    t_reset();
    t_early();
    t_late();
    t_attrs();
    t_lock();
    t_freeze();
    t_oe();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule